// File: doc/BRIEF.md
# 16-bit Coprocessor Execute Stage

This block is the execute stage of a small 16-bit RISC coprocessor. Each accepted operation carries a 4-bit opcode and three register values (destination `rd`, sources `rs1` and `rs2`), plus an 8-bit immediate. The stage works out a 16-bit result and the next condition flags: negative N, zero Z, overflow V and carry C. It registers both in one step. The flags live in a condition code register inside the stage, so each operation sees the flags left by the one accepted before it.

Operations arrive on a valid/ready input stream and leave on a valid/ready output stream. The stage holds one result. `in_ready` is high when the result register is empty, or when its result is being taken in the same cycle. This lets a new operation go in on the cycle the old one drains. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new operation is accepted. The flag register `out_ccr` is a plain status output that changes on each accepted operation.

The opcode selects one of four modes in bits 3:2 and one of four kinds in bits 1:0. In modes 0 to 2 the kind is 0 add, 1 subtract, 2 AND, 3 OR. Mode 0 is triadic (`rs1` op `rs2`). Mode 1 works on the low byte of `rd` with the immediate. Mode 2 works on the high byte of `rd` with the immediate. In mode 3 the kind is 0 logical left shift, 1 logical right shift, 2 arithmetic right shift, and 3 flag transfer. Shifts operate on `rd`.

Top module: `coproc_exec`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An operation is accepted when `in_valid && in_ready`. While `out_valid && !out_ready`, `out_valid` stays high and `out_res` does not change.
- R2: Opcodes 0 and 1 give `rs1 + rs2` and `rs1 - rs2`. N is bit 15 and Z is set for a zero result. V is signed overflow. C is the carry out for add and the borrow (`rs2 > rs1` unsigned) for subtract.
- R3: Opcodes 2 and 3 give the full-word `rs1 & rs2` and `rs1 | rs2`. They set N and Z, clear V and leave C unchanged.
- R4: Opcodes 4 to 7 apply the kind to `rd[7:0]` and `imm` and keep `rd[15:8]`. V and C come from the 8-bit add or subtract, and logic kinds clear V and keep C. N and Z reflect the full 16-bit result.
- R5: Opcodes 8 to 11 apply the kind to `rd[15:8]` and `imm` and keep `rd[7:0]`. V and C follow the same rules as in R4, taken from the 8-bit high-byte operation. N and Z reflect the full 16-bit result.
- R6: Opcodes 12, 13 and 14 shift `rd` left logically, right logically, or right arithmetically. The arithmetic right shift fills vacated bits with the original bit 15.
- R7: The shift amount is `imm[3:0]` when `in_amt_imm` is 1 and `rs2[3:0]` when it is 0. Higher bits of either source have no effect.
- R8: A shift by 0 returns `rd` unchanged and keeps C. A shift by 1 to 15 sets C to the last bit shifted out. Every shift clears V and sets N and Z from the result.
- R9: Opcode 15 returns `{12'b0, N, Z, V, C}`, with N in bit 3 and C in bit 0, and leaves all flags unchanged.
- R10: After reset, `out_valid` is 0, `out_res` is 0, `out_ccr` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Stage can take an operation this cycle |
| in_op | input | 4 | Opcode: mode in bits 3:2, kind in bits 1:0 |
| in_amt_imm | input | 1 | Shift amount source: 1 immediate, 0 `rs2` |
| in_rd | input | 16 | Destination register value |
| in_rs1 | input | 16 | First source value |
| in_rs2 | input | 16 | Second source value, or shift amount |
| in_imm | input | 8 | Immediate byte |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 16 | Registered result |
| out_ccr | output | 4 | Flags N, Z, V, C (bit 3 down to bit 0) |

## Verification
Two things can happen in the same cycle: the consumer drains one result while a new operation is accepted. That new operation may also read flags the drained one just wrote, as a logic op keeping C, a zero shift keeping C, or a flag transfer does. The bench provokes both by holding `in_valid` high back to back while `out_ready` is random. It judges each drained result and flag set against a bench model that carries its own flag state from one accepted operation to the next. Directed cases cover signed overflow, borrow, byte isolation, 15-bit shifts and register-sourced amounts with junk upper bits.

// File: rtl/exec_pkg.sv
package exec_pkg;
  typedef enum logic [1:0] {
    MD_TRI = 2'd0,
    MD_LOB = 2'd1,
    MD_HIB = 2'd2,
    MD_SFT = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    K_ADD = 2'd0,
    K_SUB = 2'd1,
    K_AND = 2'd2,
    K_OR  = 2'd3
  } kind_e;

  // kind codes reused inside shift mode
  localparam logic [1:0] SK_LSL = 2'd0;
  localparam logic [1:0] SK_LSR = 2'd1;
  localparam logic [1:0] SK_ASR = 2'd2;
  localparam logic [1:0] SK_XFR = 2'd3;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/exec_addsub.sv
module exec_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] r,
  output logic         c,
  output logic         v
);
  logic [W-1:0] bx;
  logic [W:0]   s;

  always_comb begin
    bx = sub ? ~b : b;
    s  = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub};
    r  = s[W-1:0];
    // carry for add, borrow for subtract
    c  = sub ? ~s[W] : s[W];
    v  = (a[W-1] == bx[W-1]) && (r[W-1] != a[W-1]);
  end
endmodule

// File: rtl/exec_shift.sv
module exec_shift #(
  parameter int W  = 16,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [AW-1:0] amt,
  input  logic          right,
  input  logic          arith,
  output logic [W-1:0]  r,
  output logic          c
);
  logic [W:0]   l_ext;
  logic [W:0]   r_ext;
  logic [W-1:0] a_res;

  always_comb begin
    l_ext = {1'b0, val} << amt;
    r_ext = {val, 1'b0} >> amt;
    a_res = W'($signed(val) >>> amt);
    if (right) begin
      r = arith ? a_res : r_ext[W:1];
      c = r_ext[0];
    end else begin
      r = l_ext[W-1:0];
      c = l_ext[W];
    end
  end
endmodule

// File: rtl/coproc_exec.sv
module coproc_exec #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      in_op,
  input  logic            in_amt_imm,
  input  logic [DW-1:0]   in_rd,
  input  logic [DW-1:0]   in_rs1,
  input  logic [DW-1:0]   in_rs2,
  input  logic [DW/2-1:0] in_imm,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_res,
  output logic [3:0]      out_ccr
);
  import exec_pkg::*;

  localparam int BW = DW / 2;
  localparam int AW = $clog2(DW);

  mode_e        mode;
  logic [1:0]   kind;
  logic         acc;
  flags_t       ccr, nxt_ccr;
  logic [DW-1:0] nxt_res;

  logic [DW-1:0] full_r;
  logic          full_c, full_v;
  logic [BW-1:0] byte_a, byte_r, byte_lg;
  logic          byte_c, byte_v;
  logic [AW-1:0] amt;
  logic [DW-1:0] sh_r;
  logic          sh_c;
  logic          is_arith, is_shift, is_xfr;

  assign mode     = mode_e'(in_op[3:2]);
  assign kind     = in_op[1:0];
  assign is_arith = (kind == K_ADD) || (kind == K_SUB);
  assign is_shift = (mode == MD_SFT) && (kind != SK_XFR);
  assign is_xfr   = (mode == MD_SFT) && (kind == SK_XFR);

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  exec_addsub #(.W(DW)) u_full (
    .a(in_rs1), .b(in_rs2), .sub(kind == K_SUB),
    .r(full_r), .c(full_c), .v(full_v)
  );

  assign byte_a = (mode == MD_HIB) ? in_rd[DW-1:BW] : in_rd[BW-1:0];

  exec_addsub #(.W(BW)) u_byte (
    .a(byte_a), .b(in_imm), .sub(kind == K_SUB),
    .r(byte_r), .c(byte_c), .v(byte_v)
  );

  assign byte_lg = (kind == K_AND) ? (byte_a & in_imm) : (byte_a | in_imm);

  assign amt = in_amt_imm ? in_imm[AW-1:0] : in_rs2[AW-1:0];

  exec_shift #(.W(DW), .AW(AW)) u_sh (
    .val(in_rd), .amt(amt), .right(kind != SK_LSL), .arith(kind == SK_ASR),
    .r(sh_r), .c(sh_c)
  );

  always_comb begin
    nxt_res = in_rd;
    nxt_ccr = ccr;
    case (mode)
      MD_TRI: begin
        if (is_arith) begin
          nxt_res   = full_r;
          nxt_ccr.c = full_c;
          nxt_ccr.v = full_v;
        end else begin
          nxt_res   = (kind == K_AND) ? (in_rs1 & in_rs2) : (in_rs1 | in_rs2);
          nxt_ccr.v = 1'b0;
        end
      end
      MD_LOB, MD_HIB: begin
        logic [BW-1:0] r8;
        r8 = is_arith ? byte_r : byte_lg;
        nxt_res = (mode == MD_HIB) ? {r8, in_rd[BW-1:0]} : {in_rd[DW-1:BW], r8};
        nxt_ccr.v = is_arith ? byte_v : 1'b0;
        if (is_arith) nxt_ccr.c = byte_c;
      end
      default: begin
        if (is_xfr) begin
          nxt_res = {{(DW-4){1'b0}}, ccr};
        end else begin
          nxt_res   = sh_r;
          nxt_ccr.v = 1'b0;
          if (amt != '0) nxt_ccr.c = sh_c;
        end
      end
    endcase
    if (!is_xfr) begin
      nxt_ccr.n = nxt_res[DW-1];
      nxt_ccr.z = (nxt_res == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      ccr       <= '0;
    end else if (acc) begin
      out_valid <= 1'b1;
      out_res   <= nxt_res;
      ccr       <= nxt_ccr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_ccr = ccr;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res)); // R1

  AST_LOGIC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (mode == MD_TRI) && !is_arith |=> ccr.c == $past(ccr.c)); // R3

  AST_LOW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (mode == MD_LOB) |=> out_res[DW-1:BW] == $past(in_rd[DW-1:BW])); // R4

  AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (mode == MD_HIB) |=> out_res[BW-1:0] == $past(in_rd[BW-1:0])); // R5

  AST_SHIFT_CLEARS_V: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_shift |=> !ccr.v); // R8

  AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_shift && (amt == '0) |=> out_res == $past(in_rd) && ccr.c == $past(ccr.c)); // R8

  AST_XFR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_xfr |=> ccr == $past(ccr)); // R9
endmodule

// File: tb/sim_coproc_exec.sv
module sim_coproc_exec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_amt_imm;
  logic [3:0]  in_op;
  logic [15:0] in_rd, in_rs1, in_rs2;
  logic [7:0]  in_imm;
  logic        out_valid, out_ready;
  logic [15:0] out_res;
  logic [3:0]  out_ccr;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [3:0]  mccr, exp_ccr;
  logic [15:0] exp_res;
  bit          pend;
  string       exp_tag;

  always #5 clk = ~clk;

  coproc_exec u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_amt_imm(in_amt_imm), .in_rd(in_rd), .in_rs1(in_rs1),
    .in_rs2(in_rs2), .in_imm(in_imm), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .out_ccr(out_ccr)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op[3:2])
      2'd0: return (op[1] ? "R3" : "R2");
      2'd1: return "R4";
      2'd2: return "R5";
      default: return (op[1:0] == 2'd3) ? "R9" : "R6";
    endcase
  endfunction

  // returns {flags, result}
  function automatic logic [19:0] model(input logic [3:0] op, input logic ai,
      input logic [15:0] rd, input logic [15:0] a, input logic [15:0] b,
      input logic [7:0] imm, input logic [3:0] cc);
    logic n, z, v, c;
    logic [15:0] r;
    logic [16:0] s;
    logic [8:0]  s8;
    logic [7:0]  a8, r8;
    int amt;
    {n, z, v, c} = cc;
    r = rd;
    case (op[3:2])
      2'd0: begin
        case (op[1:0])
          2'd0: begin s = {1'b0, a} + {1'b0, b}; r = s[15:0]; c = s[16];
                      v = (a[15] == b[15]) && (r[15] != a[15]); end
          2'd1: begin r = a - b; c = (b > a); v = (a[15] != b[15]) && (r[15] != a[15]); end
          2'd2: begin r = a & b; v = 1'b0; end
          default: begin r = a | b; v = 1'b0; end
        endcase
      end
      2'd1, 2'd2: begin
        a8 = op[3] ? rd[15:8] : rd[7:0];
        case (op[1:0])
          2'd0: begin s8 = {1'b0, a8} + {1'b0, imm}; r8 = s8[7:0]; c = s8[8];
                      v = (a8[7] == imm[7]) && (r8[7] != a8[7]); end
          2'd1: begin r8 = a8 - imm; c = (imm > a8); v = (a8[7] != imm[7]) && (r8[7] != a8[7]); end
          2'd2: begin r8 = a8 & imm; v = 1'b0; end
          default: begin r8 = a8 | imm; v = 1'b0; end
        endcase
        r = op[3] ? {r8, rd[7:0]} : {rd[15:8], r8};
      end
      default: begin
        if (op[1:0] == 2'd3) return {cc, 12'h000, cc};
        amt = ai ? int'(imm[3:0]) : int'(b[3:0]);
        v = 1'b0;
        for (int i = 0; i < amt; i++) begin
          if (op[1:0] == 2'd0) begin c = r[15]; r = {r[14:0], 1'b0}; end
          else begin c = r[0]; r = {(op[1] ? r[15] : 1'b0), r[15:1]}; end
        end
      end
    endcase
    n = r[15];
    z = (r == 16'h0000);
    return {n, z, v, c, r};
  endfunction

  // one clock of the handshake, entered and left just after a falling edge
  task automatic cycle(input bit rnd, output bit accepted, input string tag);
    bit drain;
    out_ready = rnd ? ($urandom % 4 != 0) : 1'b1;
    #1;
    chk(in_ready == (!out_valid || out_ready), "R1 ready", {15'b0, in_ready}, {15'b0, (!out_valid || out_ready)});
    drain    = out_valid && out_ready;
    accepted = in_valid && in_ready;
    if (drain) begin
      chk(pend, "R1 spurious valid", {15'b0, out_valid}, 16'h0);
      chk(out_res == exp_res, {exp_tag, " result"}, out_res, exp_res);
      chk(out_ccr == exp_ccr, {exp_tag, " flags"}, {12'b0, out_ccr}, {12'b0, exp_ccr});
      pend = 1'b0;
    end
    if (accepted) begin
      {exp_ccr, exp_res} = model(in_op, in_amt_imm, in_rd, in_rs1, in_rs2, in_imm, mccr);
      mccr    = exp_ccr;
      pend    = 1'b1;
      exp_tag = tag;
    end
    @(negedge clk);
  endtask

  task automatic issue(input logic [3:0] op, input logic ai, input logic [15:0] rd,
      input logic [15:0] a, input logic [15:0] b, input logic [7:0] imm,
      input bit rnd, input string tag);
    bit got;
    in_op = op; in_amt_imm = ai; in_rd = rd; in_rs1 = a; in_rs2 = b; in_imm = imm;
    in_valid = 1'b1;
    do cycle(rnd, got, tag); while (!got);
    in_valid = 1'b0;
  endtask

  function automatic logic [15:0] pick16();
    case ($urandom % 6)
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'hFFFF;
      3: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    bit got;
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_op = '0; in_amt_imm = 1'b0; in_rd = '0; in_rs1 = '0; in_rs2 = '0; in_imm = '0;
    mccr = '0; pend = 1'b0; exp_res = '0; exp_ccr = '0; exp_tag = "";
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid", {15'b0, out_valid}, 16'h0);
    chk(out_res == 16'h0, "R10 result", out_res, 16'h0);
    chk(out_ccr == 4'h0, "R10 flags", {12'b0, out_ccr}, 16'h0);
    chk(in_ready == 1'b1, "R10 ready", {15'b0, in_ready}, 16'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    issue(4'd0, 1'b0, 16'h0, 16'h7FFF, 16'h0001, 8'h00, 1'b0, "R2 add overflow");
    issue(4'd1, 1'b0, 16'h0, 16'h0000, 16'h0001, 8'h00, 1'b0, "R2 sub borrow");
    issue(4'd2, 1'b0, 16'h0, 16'hF0F0, 16'h0F0F, 8'h00, 1'b0, "R3 and keeps C");
    issue(4'd3, 1'b0, 16'h0, 16'h1200, 16'h0034, 8'h00, 1'b0, "R3 or word");
    issue(4'd8, 1'b0, 16'h7F12, 16'h0, 16'h0, 8'h01, 1'b0, "R5 addh overflow");
    issue(4'd10, 1'b0, 16'hFFFF, 16'h0, 16'h0, 8'hFE, 1'b0, "R5 andh");
    issue(4'd5, 1'b0, 16'h1200, 16'h0, 16'h0, 8'h01, 1'b0, "R4 subl borrow");
    issue(4'd7, 1'b0, 16'hA500, 16'h0, 16'h0, 8'h5A, 1'b0, "R4 orl");
    issue(4'd12, 1'b1, 16'h0001, 16'h0, 16'h0, 8'hFF, 1'b0, "R6 lsl 15");
    issue(4'd14, 1'b1, 16'h8000, 16'h0, 16'h0, 8'h0F, 1'b0, "R6 asr 15");
    issue(4'd13, 1'b0, 16'h8005, 16'h0, 16'hFFF3, 8'h00, 1'b0, "R7 amount from rs2");
    issue(4'd1, 1'b0, 16'h0, 16'h0000, 16'h0001, 8'h00, 1'b0, "R2 sub borrow");
    issue(4'd12, 1'b1, 16'h1234, 16'h0, 16'h0, 8'hF0, 1'b0, "R8 zero shift keeps C");
    issue(4'd15, 1'b0, 16'hBEEF, 16'h0, 16'h0, 8'h00, 1'b0, "R9 flag transfer");

    // random traffic with back-pressure, back to back
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] op;
      op = 4'($urandom);
      issue(op, 1'($urandom), pick16(), pick16(), pick16(), 8'($urandom), 1'b1,
            (op[3:2] == 2'd3 && op[1:0] != 2'd3) ? "R8 shift" : tag_of(op));
    end

    for (int k = 0; k < 4; k++) cycle(1'b0, got, "R1");
    chk(!pend && !out_valid, "R1 drained", {15'b0, out_valid}, 16'h0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule